// File: doc/BRIEF.md
# Floating-Point Immediate Construction Unit

This execution-stage block builds single-precision constants directly from instruction immediates, so software never needs a data-cache load to place a float constant in a 64-bit floating-point register. It implements two operations. The "load high" operation takes a 16-bit immediate as a bfloat16 value. That value becomes the upper half of a single-precision word whose lower half is zero. The "splice low" operation reads the current register value and recovers the single-precision word it holds. It then overwrites the lower 16 bits of that word with the immediate.

In both cases the resulting single-precision word is written back in double layout. The exponent is rebiased and the fraction is widened, and a single subnormal is normalised on the way. A "load high" followed by a "splice low" on the same register therefore reproduces any 32-bit single pattern exactly. Neither operation signals any floating-point status. The result and its write enable come from a register, one clock after the instruction is presented.

Top module: `fpimm_unit`

## Requirements
- R1: While reset is asserted and after its release with no instruction presented, `out_wen` is 0, `out_wdata` is all zeros and `out_flags` is all zeros.
- R2: `out_wen` is 1 in exactly the cycle after a cycle with `in_valid` high, and carries that instruction's result. After a cycle with `in_valid` low, `out_wen` is 0 and `out_wdata` keeps its previous value.
- R3: With `in_op` = 0 (load high), the single-precision word is `{in_imm, 16'h0000}` and `in_reg` has no effect. An immediate of 0x0000 writes 64 zero bits (positive zero).
- R4: A normal single word (exponent field 1..254) expands to sign at bit 63, exponent field plus 896 in bits 62:52, the 23 fraction bits in bits 51:29, and zeros in bits 28:0.
- R5: A single zero expands to its sign followed by 63 zeros. A single exponent of 255 (infinity or NaN) expands to exponent 0x7FF with the 23 fraction bits left-aligned in bits 51:29.
- R6: A single subnormal (exponent 0, fraction nonzero) is normalised. With z the number of leading zeros in the 23-bit fraction, the fraction is shifted left by z+1 with its leading one dropped, and the double exponent is 896 − z.
- R7: With `in_op` = 1 (splice low), the single word is extracted from `in_reg` and its bits 15:0 are replaced by `in_imm`. The result is expanded as in R4–R6. Extraction takes the sign from bit 63, the fraction from bits 51:29 and, for double exponents E from 897 to 2046, the single exponent (E − 896) mod 256.
- R8: In extraction, E = 2047 gives single exponent 255. E from 874 to 896 gives a single subnormal whose fraction is `{1, bits 51:29}` shifted right by 897 − E and truncated to 23 bits. E below 874 gives a signed zero.
- R9: A load high with immediate H, followed by a splice low with immediate L on the written value, produces the expansion of the 32-bit word `{H, L}` for any H and L.
- R10: `out_flags` is never nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_op | input | 1 | 0 = load high, 1 = splice low |
| in_imm | input | 16 | Instruction immediate |
| in_reg | input | 64 | Current contents of the target register |
| out_wdata | output | 64 | Register write data in double layout |
| out_wen | output | 1 | Register write enable |
| out_flags | output | 5 | Floating-point status flags, always zero |

## Verification
Every path through the block ends in one output register, so a fault in the expander, the extractor or the leading-zero counter shows on `out_wdata` exactly one clock after the instruction that uses it. Nothing is held internally to hide or delay it. A miscounted leading zero shows only for subnormal inputs, as a wrong exponent and a shifted fraction. An extraction fault shows only on splice operations, most plainly on the near-subnormal exponents and on the load-then-splice round trip. A write enable that lags or leads its data, or a data register that changes in idle cycles, is visible in the first cycle after the instruction.

// File: rtl/fpimm_pkg.sv
package fpimm_pkg;

   localparam int SP_W   = 32;
   localparam int SP_EW  = 8;
   localparam int SP_FW  = 23;
   localparam int DP_W   = 64;
   localparam int DP_EW  = 11;
   localparam int DP_FW  = 52;
   localparam int IMM_W  = 16;
   localparam int FLAG_W = 5;

   localparam int SP_BIAS = (1 << (SP_EW - 1)) - 1;
   localparam int DP_BIAS = (1 << (DP_EW - 1)) - 1;
   localparam int REBIAS  = DP_BIAS - SP_BIAS;
   localparam int FR_PAD  = DP_FW - SP_FW;

   typedef enum logic {
      OP_LOAD_HI   = 1'b0,
      OP_SPLICE_LO = 1'b1
   } fpimm_op_e;

   typedef struct packed {
      logic             sign;
      logic [SP_EW-1:0] exp;
      logic [SP_FW-1:0] frac;
   } sp_t;

   typedef struct packed {
      logic             sign;
      logic [DP_EW-1:0] exp;
      logic [DP_FW-1:0] frac;
   } dp_t;

endpackage

// File: rtl/fpimm_lzc.sv
module fpimm_lzc #(
   parameter int W  = 23,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] cnt_o,
   output logic          zero_o
);

   generate
      if (W < 2) begin : g_bad_w
         $error("fpimm_lzc: W must be at least 2");
      end
      if ((1 << CW) <= W) begin : g_bad_cw
         $error("fpimm_lzc: CW too narrow for W");
      end
   endgenerate

   logic [W-1:0] first_one;

   always_comb begin
      logic above;
      above = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         first_one[i] = vec_i[i] & ~above;
         above        = above | vec_i[i];
      end
   end

   always_comb begin
      cnt_o = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (first_one[i]) cnt_o = CW'(W - 1 - i);
      end
   end

   assign zero_o = ~|vec_i;

endmodule

// File: rtl/fpimm_sp2dp.sv
module fpimm_sp2dp
   import fpimm_pkg::*;
(
   input  sp_t sp_i,
   output dp_t dp_o
);

   localparam int LZW = $clog2(SP_FW + 1);

   generate
      if (DP_EW <= SP_EW || DP_FW <= SP_FW) begin : g_bad_fmt
         $error("fpimm_sp2dp: target format must be wider");
      end
   endgenerate

   logic [LZW-1:0] lead_z;
   logic           frac_zero;
   logic [SP_FW:0] norm_frac;
   logic           exp_all1;
   logic           exp_all0;

   fpimm_lzc #(.W(SP_FW), .CW(LZW)) u_lzc (
      .vec_i  (sp_i.frac),
      .cnt_o  (lead_z),
      .zero_o (frac_zero)
   );

   assign norm_frac = {1'b0, sp_i.frac} << (lead_z + LZW'(1));
   assign exp_all1  = &sp_i.exp;
   assign exp_all0  = ~|sp_i.exp;

   logic unused_norm_top;
   assign unused_norm_top = norm_frac[SP_FW];

   always_comb begin
      dp_o.sign = sp_i.sign;
      if (exp_all1) begin
         dp_o.exp  = '1;
         dp_o.frac = {sp_i.frac, {FR_PAD{1'b0}}};
      end else if (exp_all0 && frac_zero) begin
         dp_o.exp  = '0;
         dp_o.frac = '0;
      end else if (exp_all0) begin
         dp_o.exp  = DP_EW'(REBIAS) - DP_EW'(lead_z);
         dp_o.frac = {norm_frac[SP_FW-1:0], {FR_PAD{1'b0}}};
      end else begin
         dp_o.exp  = DP_EW'(sp_i.exp) + DP_EW'(REBIAS);
         dp_o.frac = {sp_i.frac, {FR_PAD{1'b0}}};
      end
   end

endmodule

// File: rtl/fpimm_dp2sp.sv
module fpimm_dp2sp
   import fpimm_pkg::*;
(
   input  dp_t dp_i,
   output sp_t sp_o
);

   localparam int NORM_MIN = REBIAS + 1;
   localparam int SUB_MIN  = REBIAS + 1 - SP_FW;
   localparam int SHW      = $clog2(SP_FW + 2);

   generate
      if (SUB_MIN < 1) begin : g_bad_range
         $error("fpimm_dp2sp: subnormal window underflows");
      end
   endgenerate

   logic [DP_EW-1:0] exp_rb;
   logic [DP_EW-1:0] sh_full;
   logic [SP_FW:0]   mant;
   logic [SP_FW:0]   den;
   logic [SP_FW-1:0] frac_top;

   assign frac_top = dp_i.frac[DP_FW-1 -: SP_FW];
   assign exp_rb   = dp_i.exp - DP_EW'(REBIAS);
   assign sh_full  = DP_EW'(NORM_MIN) - dp_i.exp;
   assign mant     = {1'b1, frac_top};
   assign den      = mant >> sh_full[SHW-1:0];

   logic unused_bits;
   assign unused_bits = ^{dp_i.frac[FR_PAD-1:0], exp_rb[DP_EW-1:SP_EW],
                          sh_full[DP_EW-1:SHW], den[SP_FW]};

   always_comb begin
      sp_o.sign = dp_i.sign;
      if (&dp_i.exp) begin
         sp_o.exp  = '1;
         sp_o.frac = frac_top;
      end else if (dp_i.exp >= DP_EW'(NORM_MIN)) begin
         sp_o.exp  = exp_rb[SP_EW-1:0];
         sp_o.frac = frac_top;
      end else if (dp_i.exp >= DP_EW'(SUB_MIN)) begin
         sp_o.exp  = '0;
         sp_o.frac = den[SP_FW-1:0];
      end else begin
         sp_o.exp  = '0;
         sp_o.frac = '0;
      end
   end

endmodule

// File: rtl/fpimm_unit.sv
module fpimm_unit
   import fpimm_pkg::*;
#(
   parameter int FLAGS = FLAG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_op,
   input  logic [IMM_W-1:0] in_imm,
   input  logic [DP_W-1:0]  in_reg,
   output logic [DP_W-1:0]  out_wdata,
   output logic             out_wen,
   output logic [FLAGS-1:0] out_flags
);

   generate
      if (2 * IMM_W != SP_W) begin : g_bad_imm
         $error("fpimm_unit: two immediates must fill one single word");
      end
      if (FLAGS < 1) begin : g_bad_flags
         $error("fpimm_unit: FLAGS must be positive");
      end
   endgenerate

   fpimm_op_e op;
   dp_t       reg_dp;
   sp_t       ext_sp;
   sp_t       src_sp;
   dp_t       res_dp;

   assign op     = fpimm_op_e'(in_op);
   assign reg_dp = dp_t'(in_reg);

   fpimm_dp2sp u_extract (
      .dp_i (reg_dp),
      .sp_o (ext_sp)
   );

   logic [SP_W-1:0] ext_bits;
   assign ext_bits = SP_W'(ext_sp);

   logic unused_ext_low;
   assign unused_ext_low = ^ext_bits[IMM_W-1:0];

   always_comb begin
      unique case (op)
         OP_LOAD_HI:   src_sp = sp_t'({in_imm, {IMM_W{1'b0}}});
         OP_SPLICE_LO: src_sp = sp_t'({ext_bits[SP_W-1:IMM_W], in_imm});
         default:      src_sp = '0;
      endcase
   end

   fpimm_sp2dp u_expand (
      .sp_i (src_sp),
      .dp_o (res_dp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_wdata <= '0;
         out_wen   <= 1'b0;
      end else begin
         out_wen <= in_valid;
         if (in_valid) out_wdata <= DP_W'(res_dp);
      end
   end

   assign out_flags = '0;

endmodule

// File: rtl/fpimm_unit_chk.sv
module fpimm_unit_chk
   import fpimm_pkg::*;
#(
   parameter int FLAGS = FLAG_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_op,
   input logic [IMM_W-1:0] in_imm,
   input logic [DP_W-1:0]  in_reg,
   input logic [DP_W-1:0]  out_wdata,
   input logic             out_wen,
   input logic [FLAGS-1:0] out_flags
);

   logic unused_chk;
   assign unused_chk = ^{in_reg[62:0], out_flags};

   AST_WEN_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_wen); // R2
   AST_WEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_wen); // R2
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_wdata)); // R2
   AST_ZERO_IMM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_op && in_imm == '0) |=> (out_wdata == '0)); // R3
   AST_LOAD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_op) |=> (out_wdata[63] == $past(in_imm[15]))); // R4
   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_wen |-> (out_wdata[28:0] == '0)); // R4
   AST_SPECIAL_EXP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_op && in_imm[14:7] == 8'hFF) |=> (out_wdata[62:52] == 11'h7FF)); // R5
   AST_SPLICE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op) |=> (out_wdata[63] == $past(in_reg[63]))); // R7

endmodule

bind fpimm_unit fpimm_unit_chk #(.FLAGS(FLAGS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_op     (in_op),
   .in_imm    (in_imm),
   .in_reg    (in_reg),
   .out_wdata (out_wdata),
   .out_wen   (out_wen),
   .out_flags (out_flags)
);

// File: tb/fpimm_unit_tb_top.sv
`timescale 1ns/1ps
module fpimm_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_op = 1'b0;
   logic [15:0] in_imm = '0;
   logic [63:0] in_reg = '0;
   logic [63:0] out_wdata;
   logic        out_wen;
   logic [4:0]  out_flags;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [63:0] exp_q[$];
   string       tag_q[$];
   logic [63:0] last_exp = '0;

   always #10 clk = ~clk;

   fpimm_unit dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_op     (in_op),
      .in_imm    (in_imm),
      .in_reg    (in_reg),
      .out_wdata (out_wdata),
      .out_wen   (out_wen),
      .out_flags (out_flags)
   );

   function automatic logic [63:0] ref_expand(input logic [31:0] s);
      logic [7:0]  e;
      logic [22:0] f;
      logic [23:0] m;
      int          ex;
      e = s[30:23];
      f = s[22:0];
      if (e == 8'hFF) return {s[31], 11'h7FF, f, 29'h0};
      if (e != 8'h00) return {s[31], 11'(int'(e) + 896), f, 29'h0};
      if (f == '0) return {s[31], 63'h0};
      m  = {1'b0, f};
      ex = 897;
      while (!m[23]) begin
         m  = m << 1;
         ex = ex - 1;
      end
      return {s[31], 11'(ex), m[22:0], 29'h0};
   endfunction

   function automatic logic [31:0] ref_extract(input logic [63:0] d);
      int          e;
      logic [23:0] m;
      e = int'(d[62:52]);
      if (e == 2047) return {d[63], 8'hFF, d[51:29]};
      if (e >= 897) return {d[63], 8'(e - 896), d[51:29]};
      if (e >= 874) begin
         m = {1'b1, d[51:29]};
         m = m >> (897 - e);
         return {d[63], 8'h00, m[22:0]};
      end
      return {d[63], 31'h0};
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic drive(input logic op, input logic [15:0] imm, input logic [63:0] rv,
                        input logic [63:0] expv, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = op;
      in_imm   = imm;
      in_reg   = rv;
      exp_q.push_back(expv);
      tag_q.push_back(tag);
      last_exp = expv;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_reg   = 64'hDEAD_BEEF_0BAD_F00D;
      end
   endtask

   // monitor: pops one expected item per write-enable pulse
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (rst_n) begin
            if (out_wen) begin
               if (exp_q.size() == 0) begin
                  check("R2 spurious write enable", {63'h0, out_wen}, 64'h0);
               end else begin
                  logic [63:0] e;
                  string       t;
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  check(t, out_wdata, e);
                  check("R10 flags quiet", {59'h0, out_flags}, 64'h0);
               end
            end else if (exp_q.size() != 0) begin
               check("R2 missing write enable", {63'h0, out_wen}, 64'h1);
               void'(exp_q.pop_front());
               void'(tag_q.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] hi_res;
      logic [63:0] rv;
      logic [15:0] hs[6];
      logic [15:0] ls[6];

      repeat (3) @(negedge clk);
      check("R1 reset wen", {63'h0, out_wen}, 64'h0);
      check("R1 reset wdata", out_wdata, 64'h0);
      check("R1 reset flags", {59'h0, out_flags}, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset wen", {63'h0, out_wen}, 64'h0);

      // load high: zero, normals, specials, subnormals
      drive(1'b0, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R3 zero imm clears");
      drive(1'b0, 16'h3F80, 64'h1234_5678_9ABC_DEF0, 64'h3FF0_0000_0000_0000, "R4 one");
      drive(1'b0, 16'hC040, 64'h0, 64'hC008_0000_0000_0000, "R4 minus three");
      drive(1'b0, 16'h7F7F, 64'h0, ref_expand(32'h7F7F_0000), "R4 large normal");
      drive(1'b0, 16'h7F80, 64'h0, 64'h7FF0_0000_0000_0000, "R5 infinity");
      drive(1'b0, 16'hFFC0, 64'h0, 64'hFFF8_0000_0000_0000, "R5 quiet NaN");
      drive(1'b0, 16'h7F81, 64'h0, ref_expand(32'h7F81_0000), "R5 signalling NaN");
      drive(1'b0, 16'h8000, 64'h0, 64'h8000_0000_0000_0000, "R5 negative zero");
      drive(1'b0, 16'h0040, 64'h0, 64'h3800_0000_0000_0000, "R6 subnormal top bit");
      drive(1'b0, 16'h8001, 64'h0, ref_expand(32'h8001_0000), "R6 subnormal low bit");
      idle(3);
      check("R2 idle wen low", {63'h0, out_wen}, 64'h0);
      check("R2 idle data held", out_wdata, last_exp);

      // splice low on assorted register contents
      rv = 64'h3FF0_0000_0000_0000;
      drive(1'b1, 16'h1234, rv, ref_expand({ref_extract(rv)[31:16], 16'h1234}), "R7 splice on one");
      rv = 64'hC123_4567_89AB_CDEF;
      drive(1'b1, 16'hFFFF, rv, ref_expand({ref_extract(rv)[31:16], 16'hFFFF}), "R7 splice normal");
      rv = 64'h7FF8_0000_2000_0000;
      drive(1'b1, 16'h0001, rv, ref_expand({ref_extract(rv)[31:16], 16'h0001}), "R8 splice NaN");
      rv = {1'b0, 11'd890, 52'hA_BCDE_F012_3456};
      drive(1'b1, 16'h5555, rv, ref_expand({ref_extract(rv)[31:16], 16'h5555}), "R8 splice near subnormal");
      rv = {1'b1, 11'd874, 52'h0};
      drive(1'b1, 16'h00F0, rv, ref_expand({ref_extract(rv)[31:16], 16'h00F0}), "R8 splice lowest window");
      rv = {1'b1, 11'd800, 52'hF_FFFF_FFFF_FFFF};
      drive(1'b1, 16'hAAAA, rv, ref_expand({16'h8000, 16'hAAAA}), "R8 splice tiny to zero");
      idle(2);

      // load high then splice low reproduces exact words
      hs = '{16'h0000, 16'h7F7F, 16'h7FC0, 16'h8012, 16'h4049, 16'h0012};
      ls = '{16'h0001, 16'hFFFF, 16'h0001, 16'h3456, 16'h0FDB, 16'h8000};
      for (int k = 0; k < 6; k++) begin
         hi_res = ref_expand({hs[k], 16'h0});
         drive(1'b0, hs[k], 64'h0, hi_res, "R9 first step");
         drive(1'b1, ls[k], hi_res, ref_expand({hs[k], ls[k]}), "R9 exact round trip");
      end
      idle(3);
      check("R2 final idle wen", {63'h0, out_wen}, 64'h0);
      check("R10 final flags", {59'h0, out_flags}, 64'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule